// File: doc/BRIEF.md
# Move-Triggered Processor Core

This block is a small processor core with exactly one instruction. Each 32-bit instruction word names a source address and a destination address. Executing it copies one 32-bit word from the source to the destination. There is no opcode field. Data memory, an adder, a subtractor, the program counter, a condition-flag register and a condition-mask register all share one 16-bit address space. Writing the trigger input of a function unit starts that unit's operation. Writing the program counter performs a jump.

The core has a fixed two-cycle rhythm. In the fetch cycle it presents the program counter to an external synchronous instruction memory. In the execute cycle it decodes the returned word, performs the move and updates the program counter. Conditional behaviour comes from a skip test. When the condition flags ANDed with the mask give a nonzero result, the current instruction does nothing and the program counter still advances. Every move that is carried out appears on a write-bus output, so the surrounding logic can watch the results.

Top module: `moveCore`

## Requirements
- R1: While reset is asserted the core performs no moves and presents instruction address 0. After reset the first fetch is from address 0, and the flag and mask registers start at zero.
- R2: Fetch cycles and execute cycles alternate, starting with fetch. A move can be reported only in an execute cycle. Every instruction that does not jump advances the program counter by exactly one.
- R3: Instruction bits [31:16] hold the source address and bits [15:0] hold the destination address. Data memory occupies addresses 0 to 15. A move copies the source word unchanged to the destination, and the write bus shows the destination address and the data.
- R4: A source address with bit 15 set reads as a constant: bits [14:0] of the address, zero-extended to 32 bits.
- R5: The adder's first operand is at 0x0100. A write to 0x0101 triggers the sum of the first operand and the written word. That sum is then readable at 0x0112 minus 0x10, that is at 0x0102.
- R6: The subtractor's first operand is at 0x0110. A write to 0x0111 triggers the first operand minus the written word. The difference is readable at 0x0112. The same write sets flag bit 0 when the difference is zero and flag bit 1 to bit 31 of the difference.
- R7: Reading 0x0120 returns the address of the instruction being executed. Writing 0x0120 makes the written word the next program counter.
- R8: When flags AND mask is nonzero at the start of an instruction, that instruction writes nothing and triggers nothing, and the program counter advances by one.
- R9: The flag register (0x0121) is readable and writable. Flags loaded by a subtract trigger or by a direct write are visible only to the next instruction, and they are cleared at the end of every other instruction, including skipped ones.
- R10: An unmapped source reads as zero. A write to an unmapped destination changes no state.
- R11: The mask register (0x0122) holds the low two bits written to it and reads them back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| imemAddr | output | 16 | Instruction memory address (program counter) |
| imemData | input | 32 | Instruction word, valid one cycle after the address |
| busWrEn | output | 1 | A move is performed this cycle |
| busWrAddr | output | 16 | Destination address of the move |
| busWrData | output | 32 | Word carried by the move |

## Verification
The embedded assertions check four properties on every cycle: moves never occur in back-to-back cycles, each instruction steps or loads the program counter as expected, fetch cycles leave the program counter and flags unchanged, and flags clear unless an instruction loads them. They also check that a skipped instruction leaves the mask and the sequential program counter untouched. Only the bench's program can show that the values carried are right: sums and differences, constants, the program counter as a source, the flag contents one instruction after a trigger, and unmapped addresses reading back as zero. The bench compares every cycle against a behavioural model and also checks the final memory contents against hand-worked values.

// File: rtl/moveCorePkg.sv
package moveCorePkg;
  typedef enum logic {PH_FETCH, PH_EXEC} phase_e;

  // control to datapath strobes
  typedef struct packed {
    logic exec;    // execute cycle of an instruction
    logic commit;  // move is carried out (not skipped)
  } strobe_t;

  localparam int unsigned FLAG_W = 2;  // bit0 zero, bit1 sign

  localparam logic [15:0] ADDR_ADD_A   = 16'h0100;
  localparam logic [15:0] ADDR_ADD_TRG = 16'h0101;
  localparam logic [15:0] ADDR_ADD_SUM = 16'h0102;
  localparam logic [15:0] ADDR_SUB_A   = 16'h0110;
  localparam logic [15:0] ADDR_SUB_TRG = 16'h0111;
  localparam logic [15:0] ADDR_SUB_DIF = 16'h0112;
  localparam logic [15:0] ADDR_PC      = 16'h0120;
  localparam logic [15:0] ADDR_FLAGS   = 16'h0121;
  localparam logic [15:0] ADDR_MASK    = 16'h0122;
endpackage

// File: rtl/moveCtrl.sv
module moveCtrl
  import moveCorePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    condHit,
  output strobe_t stb
);
  phase_e phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_FETCH;
    else       phase <= (phase == PH_FETCH) ? PH_EXEC : PH_FETCH;
  end

  always_comb begin
    stb.exec   = (phase == PH_EXEC);
    stb.commit = (phase == PH_EXEC) && !condHit;
  end

  // R2: a move is never followed by another move in the next cycle
  assert_alternate_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> !stb.commit);
endmodule

// File: rtl/moveDatapath.sv
module moveDatapath
  import moveCorePkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RAM_WORDS = 16,
  parameter int unsigned IADDR_W   = 16
)(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [31:0]         instr,
  output logic                condHit,
  output logic [IADDR_W-1:0]  imemAddr,
  output logic                busWrEn,
  output logic [15:0]         busWrAddr,
  output logic [DATA_W-1:0]   busWrData
);
  localparam int unsigned RAM_AW = $clog2(RAM_WORDS);

  logic [DATA_W-1:0] ram [RAM_WORDS];
  logic [DATA_W-1:0] pc, addA, addSum, subA, subDif, srcData, difNext;
  logic [FLAG_W-1:0] flags, mask;
  logic [15:0]       srcAddr, dstAddr;
  logic              srcInRam, dstInRam, flagLoad, pcLoad;

  assign srcAddr  = instr[31:16];
  assign dstAddr  = instr[15:0];
  assign srcInRam = !srcAddr[15] && (srcAddr < 16'(RAM_WORDS));
  assign dstInRam = (dstAddr < 16'(RAM_WORDS));
  assign condHit  = |(flags & mask);
  assign difNext  = subA - srcData;

  always_comb begin
    srcData = '0;
    if (srcAddr[15])   srcData = DATA_W'(srcAddr[14:0]);
    else if (srcInRam) srcData = ram[srcAddr[RAM_AW-1:0]];
    else begin
      case (srcAddr)
        ADDR_ADD_A:   srcData = addA;
        ADDR_ADD_SUM: srcData = addSum;
        ADDR_SUB_A:   srcData = subA;
        ADDR_SUB_DIF: srcData = subDif;
        ADDR_PC:      srcData = pc;
        ADDR_FLAGS:   srcData = DATA_W'(flags);
        ADDR_MASK:    srcData = DATA_W'(mask);
        default:      srcData = '0;
      endcase
    end
  end

  assign busWrEn   = stb.commit;
  assign busWrAddr = dstAddr;
  assign busWrData = srcData;
  assign pcLoad    = stb.commit && (dstAddr == ADDR_PC);
  assign flagLoad  = stb.commit && ((dstAddr == ADDR_SUB_TRG) || (dstAddr == ADDR_FLAGS));
  assign imemAddr  = pc[IADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0; flags <= '0; mask <= '0;
      addA <= '0; addSum <= '0; subA <= '0; subDif <= '0;
    end else if (stb.exec) begin
      pc <= pcLoad ? srcData : pc + 1'b1;
      if (stb.commit && dstAddr == ADDR_SUB_TRG)
        flags <= {difNext[DATA_W-1], (difNext == '0)};
      else if (stb.commit && dstAddr == ADDR_FLAGS)
        flags <= srcData[FLAG_W-1:0];
      else
        flags <= '0;
      if (stb.commit) begin
        case (dstAddr)
          ADDR_ADD_A:   addA   <= srcData;
          ADDR_ADD_TRG: addSum <= addA + srcData;
          ADDR_SUB_A:   subA   <= srcData;
          ADDR_SUB_TRG: subDif <= difNext;
          ADDR_MASK:    mask   <= srcData[FLAG_W-1:0];
          default: ;
        endcase
      end
    end
  end

  generate
    for (genvar i = 0; i < RAM_WORDS; i++) begin : g_ram
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ram[i] <= '0;
        else if (stb.commit && dstInRam && dstAddr[RAM_AW-1:0] == RAM_AW'(i))
          ram[i] <= srcData;
      end
    end
  endgenerate

  // R2: non-jumping instructions step the program counter by one
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.exec && !(busWrEn && busWrAddr == ADDR_PC)) |=> pc == $past(pc) + 1'b1);
  // R2: fetch cycles leave architectural state alone
  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.exec |=> ($stable(pc) && $stable(flags)));
  // R7: a move to the PC address becomes the next program counter
  assert_jump_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busWrAddr == ADDR_PC) |=> pc == $past(busWrData));
  // R8: a skipped instruction keeps the mask and steps the PC
  assert_skip_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.exec && |(flags & mask)) |=> ($stable(mask) && pc == $past(pc) + 1'b1));
  // R9: flags clear after any instruction that does not load them
  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.exec && !(busWrEn && (busWrAddr == ADDR_SUB_TRG || busWrAddr == ADDR_FLAGS)))
      |=> flags == '0);
endmodule

// File: rtl/moveCore.sv
module moveCore
  import moveCorePkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RAM_WORDS = 16,
  parameter int unsigned IADDR_W   = 16
)(
  input  logic               clk,
  input  logic               rstN,
  output logic [IADDR_W-1:0] imemAddr,
  input  logic [31:0]        imemData,
  output logic               busWrEn,
  output logic [15:0]        busWrAddr,
  output logic [DATA_W-1:0]  busWrData
);
  strobe_t stb;
  logic    condHit;

  moveCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .condHit(condHit), .stb(stb)
  );

  moveDatapath #(.DATA_W(DATA_W), .RAM_WORDS(RAM_WORDS), .IADDR_W(IADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .instr(imemData), .condHit(condHit),
    .imemAddr(imemAddr), .busWrEn(busWrEn), .busWrAddr(busWrAddr), .busWrData(busWrData)
  );
endmodule

// File: tb/moveCore_bench.sv
module moveCore_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] imemAddr;
  logic [31:0] imemData = '0;
  logic        busWrEn;
  logic [15:0] busWrAddr;
  logic [31:0] busWrData;

  int checks = 0;
  int errors = 0;

  moveCore u_moveCore (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .busWrEn(busWrEn), .busWrAddr(busWrAddr), .busWrData(busWrData)
  );

  always #5 clk = ~clk;

  // program
  logic [31:0] prog [64];
  function automatic logic [31:0] mv(logic [15:0] s, logic [15:0] d);
    return {s, d};
  endfunction
  function automatic logic [15:0] k(int v);
    return 16'h8000 | 16'(v);
  endfunction

  always @(posedge clk) imemData <= prog[imemAddr[5:0]];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mPc, mAddA, mAddS, mSubA, mSubD;
  logic [1:0]  mFlags, mMask;
  logic [31:0] mRam [16];
  bit          mExec;
  bit          firstFetch;
  logic [31:0] seenVal [16];
  bit          seen [16];

  function automatic logic [31:0] mRead(logic [15:0] a);
    if (a[15]) return {17'b0, a[14:0]};
    if (a < 16) return mRam[a[3:0]];
    case (a)
      16'h0100: return mAddA;
      16'h0102: return mAddS;
      16'h0110: return mSubA;
      16'h0112: return mSubD;
      16'h0120: return mPc;
      16'h0121: return {30'b0, mFlags};
      16'h0122: return {30'b0, mMask};
      default:  return 32'h0;
    endcase
  endfunction

  function automatic string kindTag(logic [15:0] s, logic [15:0] d);
    if (d == 16'h0120) return "R7";
    if (s[15]) return "R4";
    if (s == 16'h0102) return "R5";
    if (s == 16'h0112) return "R6";
    if (s == 16'h0121) return "R9";
    if (s == 16'h0122) return "R11";
    if (s == 16'h0120) return "R7";
    if (s >= 16) return "R10";
    return "R3";
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      check(busWrEn == 1'b0, "R1 no move in reset", {31'b0, busWrEn}, 32'h0);
      check(imemAddr == 16'h0, "R1 reset address", {16'b0, imemAddr}, 32'h0);
      mPc = 0; mFlags = 0; mMask = 0; mAddA = 0; mAddS = 0; mSubA = 0; mSubD = 0;
      for (int i = 0; i < 16; i++) begin mRam[i] = 0; seen[i] = 0; seenVal[i] = 0; end
      mExec = 0; firstFetch = 1;
    end else if (!mExec) begin
      check(busWrEn == 1'b0, "R2 no move in fetch", {31'b0, busWrEn}, 32'h0);
      check(imemAddr == mPc[15:0], firstFetch ? "R1 first fetch" : "R7 fetch address",
            {16'b0, imemAddr}, mPc);
      firstFetch = 0;
      mExec = 1;
    end else begin
      logic [31:0] ins, val;
      logic [15:0] s, d;
      bit skip;
      logic [1:0] nf;
      ins = prog[mPc[5:0]]; s = ins[31:16]; d = ins[15:0];
      skip = |(mFlags & mMask);
      val = mRead(s);
      check(busWrEn == !skip, skip ? "R8 skip" : "R2 move", {31'b0, busWrEn}, {31'b0, !skip});
      if (!skip && busWrEn) begin
        check(busWrAddr == d, "R3 destination", {16'b0, busWrAddr}, {16'b0, d});
        check(busWrData == val, kindTag(s, d), busWrData, val);
        if (d < 16) begin seen[d[3:0]] = 1; seenVal[d[3:0]] = busWrData; end
      end
      nf = 2'b00;
      if (!skip) begin
        if (d < 16) mRam[d[3:0]] = val;
        case (d)
          16'h0100: mAddA = val;
          16'h0101: mAddS = mAddA + val;
          16'h0110: mSubA = val;
          16'h0111: begin mSubD = mSubA - val; nf = {mSubD[31], mSubD == 0}; end
          16'h0121: nf = val[1:0];
          16'h0122: mMask = val[1:0];
          default: ;
        endcase
      end
      mPc = (!skip && d == 16'h0120) ? val : mPc + 1;
      mFlags = nf;
      mExec = 0;
    end
  end

  task automatic expectWord(int a, logic [31:0] exp, string tag);
    check(seen[a] && seenVal[a] == exp, tag, seenVal[a], exp);
  endtask
  task automatic expectNone(int a, string tag);
    check(!seen[a], tag, {31'b0, seen[a]}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[0]  = mv(k(5), 16'h0000);
    prog[1]  = mv(16'h0000, 16'h0100);
    prog[2]  = mv(k(7), 16'h0101);
    prog[3]  = mv(16'h0102, 16'h0001);
    prog[4]  = mv(k(3), 16'h0110);
    prog[5]  = mv(k(9), 16'h0111);
    prog[6]  = mv(16'h0121, 16'h0002);
    prog[7]  = mv(16'h0121, 16'h0003);
    prog[8]  = mv(16'h0112, 16'h0004);
    prog[9]  = mv(k(2), 16'h0122);
    prog[10] = mv(k(9), 16'h0111);
    prog[11] = mv(k(16'h44), 16'h0005);
    prog[12] = mv(k(16'h55), 16'h0006);
    prog[13] = mv(16'h0122, 16'h0007);
    prog[14] = mv(k(3), 16'h0111);
    prog[15] = mv(k(16'h66), 16'h0008);
    prog[16] = mv(k(1), 16'h0122);
    prog[17] = mv(k(3), 16'h0111);
    prog[18] = mv(k(16'h77), 16'h0009);
    prog[19] = mv(16'h0120, 16'h000A);
    prog[20] = mv(k(16'h7FFF), 16'h000B);
    prog[21] = mv(k(16'h99), 16'h0050);
    prog[22] = mv(16'h0050, 16'h000C);
    prog[23] = mv(k(1), 16'h0121);
    prog[24] = mv(k(16'h88), 16'h000D);
    prog[25] = mv(k(30), 16'h0120);
    for (int i = 26; i < 30; i++) prog[i] = mv(k(16'hBAD), 16'h000E);
    prog[30] = mv(k(16'h11), 16'h000F);
    prog[31] = mv(k(31), 16'h0120);

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (140) @(posedge clk);
    @(negedge clk);
    #1;
    expectWord(0, 32'd5, "R3 constant into memory");
    expectWord(1, 32'd12, "R5 sum 5+7");
    expectWord(2, 32'd2, "R9 sign flag seen next instruction");
    expectWord(3, 32'd0, "R9 flags cleared after one instruction");
    expectWord(4, 32'hFFFF_FFFA, "R6 difference 3-9");
    expectNone(5, "R8 sign flag with mask skips");
    expectWord(6, 32'h55, "R8 instruction after skip runs");
    expectWord(7, 32'd2, "R11 mask reads back");
    expectWord(8, 32'h66, "R8 zero flag not enabled by mask");
    expectNone(9, "R8 zero flag with mask skips");
    expectWord(10, 32'd19, "R7 PC read gives own address");
    expectWord(11, 32'h7FFF, "R4 widest constant");
    expectWord(12, 32'd0, "R10 unmapped write then read");
    expectNone(13, "R9 direct flag write causes skip");
    expectNone(14, "R7 jump passes over code");
    expectWord(15, 32'h11, "R7 jump target runs");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule